// File: doc/BRIEF.md
# Lap Time Store and Recall

This block sits between a running stopwatch and its six-digit display. It takes the six live BCD digits of the running time and a single split key, and chooses what the display shows. Each press of the split key moves a mode counter one step around a fixed cycle of seven modes. Three of these modes capture the live time into one of three lap slots. In those modes, and in one further mode, the live time stays on the display. The remaining three modes play the stored laps back one at a time. The next press after the last playback mode starts a new round of captures.

The block never stops or alters the stopwatch. The live digits keep advancing while laps are shown. When the cycle comes back to a live mode, the display again follows the current time. Key debouncing and the time counter are outside the block. The split input is a clean pulse, and every clock cycle in which it is high counts as one press.

Top module: `lap_recall`

## Requirements
- R1: While reset is active and just after it, the mode output is 3 and all three lap slots hold zero. In mode 3 the display follows the live digits.
- R2: Each clock edge with split high moves the mode from m to m+1, and from 6 to 0. The mode is a 3-bit binary value. An edge with split low leaves the mode unchanged.
- R3: The press that enters mode 0, 1 or 2 loads lap slot 1, 2 or 3 respectively. The slot takes the live digits present at that same clock edge.
- R4: A lap slot changes only on the press that enters its own capture mode. Live digits that keep changing at other times do not alter it.
- R5: In modes 0, 1, 2 and 3 the display equals the live digits in the same cycle, with no register delay.
- R6: In modes 4, 5 and 6 the display shows lap slot 1, 2 and 3 respectively.
- R7: While a lap is shown, changes on the live digits do not reach the display. After the cycle wraps to mode 0, the display shows the live time as it stands then.
- R8: The digit bus packs digit i (i = 0 for hundredths up to 5 for tens of minutes) into bits 4i+3 down to 4i, on both the live and the display side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| split | input | 1 | Split key pulse, one press per high cycle |
| live_digits | input | 24 | Six live BCD digits of the running time |
| show_digits | output | 24 | Six BCD digits for the display |
| mode | output | 3 | Current mode, 0 to 6 |

## Verification
A press takes effect at the clock edge where split is sampled high. The new mode, and any slot captured at that edge, are visible in the same cycle after the edge, so one register lies between a press and its result. The display is a combinational choice between the live digits and the slots. In live modes it follows a change on live_digits with no delay. The bench runs a behavioural model that updates on the same edge as the design, and compares the mode and the display at each falling edge, after the inputs of that cycle have settled.

// File: rtl/lap_recall.sv
module lap_recall #(
  parameter int DIGITS  = 6,
  parameter int DIGIT_W = 4,
  parameter int SLOTS   = 3,
  parameter int MODE_W  = $clog2(2 * SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        split,
  input  logic [DIGITS*DIGIT_W-1:0]   live_digits,
  output logic [DIGITS*DIGIT_W-1:0]   show_digits,
  output logic [MODE_W-1:0]           mode
);
  localparam int TW = DIGITS * DIGIT_W;
  localparam logic [MODE_W-1:0] LAST_M = MODE_W'(2 * SLOTS);
  localparam logic [MODE_W-1:0] LIVE_M = MODE_W'(SLOTS);

  logic [TW-1:0]     lap_q [SLOTS];
  logic [MODE_W-1:0] mode_next;

  assign mode_next = (mode == LAST_M) ? '0 : mode + MODE_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     mode <= LIVE_M;
    else if (split) mode <= mode_next;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                    lap_q[k] <= '0;
      else if (split && mode_next == MODE_W'(k))     lap_q[k] <= live_digits;

    // R3: capture on entry to the slot's own mode
    assert_lap_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (split && mode == ((k == 0) ? LAST_M : MODE_W'(k - 1))) |=> lap_q[k] == $past(live_digits));
    // R4: slot held whenever no press occurs
    assert_lap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !split |=> $stable(lap_q[k]));
    // R6: playback mode shows its slot
    assert_playback_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_W'(SLOTS + 1 + k)) |-> show_digits == lap_q[k]);
  end

  always_comb begin
    show_digits = live_digits;
    for (int k = 0; k < SLOTS; k++)
      if (mode == MODE_W'(SLOTS + 1 + k)) show_digits = lap_q[k];
  end

  // R2: mode stays within range
  assert_mode_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= LAST_M);
  // R2: wrap from the last mode
  assert_mode_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (split && mode == LAST_M) |=> mode == '0);
  // R2: hold without a press
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !split |=> $stable(mode));
  // R5: live modes pass the live digits through
  assert_live_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode <= LIVE_M) |-> show_digits == live_digits);
endmodule

// File: tb/tb_lap_recall.sv
module tb_lap_recall;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        split = 1'b0;
  logic [23:0] live_digits = '0;
  logic [23:0] show_digits;
  logic [2:0]  mode;

  int tests = 0, fails = 0;
  int centis = 0;
  int seed = 32'h1357_2468;
  int m_mode = 3;
  logic [23:0] m_lap [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  lap_recall dut (.clk(clk), .rst_n(rst_n), .split(split),
                  .live_digits(live_digits), .show_digits(show_digits), .mode(mode));

  // R8: digit i at bits 4i+3:4i, hundredths first
  function automatic logic [23:0] to_bcd(int cs);
    logic [23:0] r;
    r[3:0]   = 4'(cs % 10);
    r[7:4]   = 4'((cs / 10) % 10);
    r[11:8]  = 4'((cs / 100) % 10);
    r[15:12] = 4'((cs / 1000) % 6);
    r[19:16] = 4'((cs / 6000) % 10);
    r[23:20] = 4'((cs / 60000) % 6);
    return r;
  endfunction

  function automatic int next_rand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_mode = 3;
      for (int k = 0; k < 3; k++) m_lap[k] = '0;
    end else if (split) begin
      m_mode = (m_mode + 1) % 7;
      if (m_mode < 3) m_lap[m_mode] = live_digits;
    end

  task automatic check_now();
    logic [23:0] exp_show;
    exp_show = (m_mode >= 4) ? m_lap[m_mode-4] : live_digits;
    tests++;
    if (mode !== 3'(m_mode)) begin
      fails++;
      $display("FAIL R2 mode: got %0d expected %0d", mode, m_mode);
    end
    tests++;
    if (show_digits !== exp_show) begin
      fails++;
      if (m_mode >= 4)
        $display("FAIL R3 R4 R6 playback: got %h expected %h", show_digits, exp_show);
      else
        $display("FAIL R5 R7 R8 live: got %h expected %h", show_digits, exp_show);
    end
  endtask

  task automatic run(int cycles, int press_odds, int max_step);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_now();
      split = (press_odds == 1) ? 1'b1 : ((next_rand() % press_odds) == 0);
      centis = (centis + (next_rand() % (max_step + 1))) % 360000;
      live_digits = to_bcd(centis);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (mode !== 3'd3 || show_digits !== live_digits) begin
      fails++;
      $display("FAIL R1 reset: mode %0d show %h expected mode 3 show %h", mode, show_digits, live_digits);
    end
    @(negedge clk); rst_n = 1'b1;
    split = 1'b1; @(negedge clk); split = 1'b0;
    tests++;
    if (mode !== 3'd4 || show_digits !== 24'h0) begin
      fails++;
      $display("FAIL R1 cleared slot: mode %0d show %h expected mode 4 show 000000", mode, show_digits);
    end
    run(400, 8, 3);
    run(25, 1, 2);
    run(300, 4, 500);
    @(negedge clk); rst_n = 1'b0; split = 1'b1;
    @(negedge clk); check_now(); split = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    run(400, 6, 40);
    run(14, 1, 1);
    run(200, 3, 7000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule